// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block fronts a one-time-programmable fuse array of 8192 bits, seen as 1024 bytes, and builds only the read side. Software first writes two timing values into a configuration register. It then writes a starting byte address, a byte count minus one and a run bit into a control register. The controller fetches that many consecutive bytes from the array. It spends a programmable number of bus clock cycles on each byte: an address-adjust phase, then a strobe phase. Each byte is dropped into a bank of eight 32-bit data registers.

When the last byte has landed, the run bit clears itself and a sticky done flag appears in the status register. An optional interrupt line reflects that flag when the interrupt is enabled. All register access goes through a plain 32-bit register bus with address, write strobe, read strobe and data. The array itself is a behavioural byte memory. A side load port fills it, standing in for factory-burnt contents. Programming and burning fuses are outside this block.

Top module: `fuse_read_ctl`

## Requirements
- R1: After reset the control, configuration, status and all eight data registers read 0, and `irq` is 0.
- R2: Register word index (bus byte address / 4) selects: 0 control, 1 configuration, 2 status, 3+n data word n (n = 0..7). Control fields: bit 0 run, bit 1 write request, bit 15 program request, bits [20:16] count minus one, bits [30:21] start byte address; other control bits read 0. Configuration fields: bits [11:0] write strobe, [15:12] write adjust, [19:16] read strobe, [23:20] read adjust, bit 31 interrupt enable; other bits read 0.
- R3: A control write with bit 0 set while idle starts a burst. From the next cycle, status bit 0 reads 0 and control bit 0 reads 1 until the burst ends.
- R4: Each byte takes (read adjust + 5 + read strobe) cycles, the first (read adjust + 1) being the address-adjust phase. Done rises exactly that figure times (count minus one + 1) cycles after the starting write edge.
- R5: A burst reads (count minus one + 1) bytes from consecutive byte addresses beginning at the start address. Byte k goes to data word k/4, bits [8·(k%4)+7 : 8·(k%4)]. Data bytes beyond the burst keep their earlier values.
- R6: Byte addresses past 1023 wrap to 0.
- R7: When the burst ends, control bit 0 clears and the rest of the control register is kept. Status bit 0 stays 1 until the next start.
- R8: `irq` equals configuration bit 31 AND status bit 0.
- R9: Write and program request bits are stored and read back, but start no activity. Status bit 1 always reads 0.
- R10: Any control write during a burst is ignored: the register keeps its value and the burst runs unchanged.
- R11: The read adjust and read strobe values are captured at the start. A configuration write during a burst does not change that burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, 0 when not reading |
| irq | output | 1 | Completion interrupt |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | 10 | Array load byte address |
| ld_data | input | 8 | Array load byte |

## Verification
The in-line properties assume one register operation per cycle. They also assume the array is loaded only while no burst runs, so the byte fetched at each capture is the one the bench modelled. The stimulus keeps to this by filling the array once after reset and never touching the load port again. Every bus access is a single-cycle strobe driven at the falling edge. Timing values stay within their 4-bit fields. The only mid-burst traffic is the deliberate control and configuration writes that probe R10 and R11.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_CFG  = 1;
   localparam int unsigned IDX_STAT = 2;
   localparam int unsigned IDX_DATA = 3;

   localparam int unsigned CTRL_RUN_BIT  = 0;
   localparam int unsigned CTRL_LEN_LSB  = 16;
   localparam int unsigned CTRL_ADDR_LSB = 21;
   localparam int unsigned CFG_RSTB_LSB  = 16;
   localparam int unsigned CFG_RADJ_LSB  = 20;
   localparam int unsigned CFG_IE_BIT    = 31;

   localparam logic [31:0] CTRL_KEEP = 32'h7FFF_8003;
   localparam logic [31:0] CFG_KEEP  = 32'h80FF_FFFF;

   typedef logic [31:0] word_t;
endpackage

// File: rtl/fuse_byte_array.sv
module fuse_byte_array #(
   parameter int unsigned BYTES = 1024,
   parameter int unsigned AW    = 10
) (
   input  logic          clk,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] cells [BYTES];

   always_ff @(posedge clk) begin
      if (ld_en) cells[ld_addr] <= ld_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
   parameter int unsigned FAW   = 10,
   parameter int unsigned LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [FAW-1:0]   base_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [3:0]       adj_i,
   input  logic [3:0]       stb_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             cap_en_o,
   output logic             fin_o,
   output logic             adj_phase_o,
   output logic [LEN_W-1:0] cap_idx_o,
   output logic [FAW-1:0]   fuse_addr_o
);
   localparam int unsigned CW = 6;

   logic             busy_q, done_q, start;
   logic [FAW-1:0]   base_q;
   logic [LEN_W-1:0] len_q, idx_q;
   logic [3:0]       adj_q, stb_q;
   logic [CW-1:0]    cyc_q, last;

   assign start       = req_i && !busy_q;
   assign last        = CW'(adj_q) + CW'(stb_q) + CW'(4);
   assign cap_en_o    = busy_q && (cyc_q == last);
   assign fin_o       = cap_en_o && (idx_q == len_q);
   assign adj_phase_o = busy_q && (cyc_q <= CW'(adj_q));
   assign cap_idx_o   = idx_q;
   assign fuse_addr_o = base_q + FAW'(idx_q);
   assign busy_o      = busy_q;
   assign done_o      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         base_q <= '0;
         len_q  <= '0;
         adj_q  <= '0;
         stb_q  <= '0;
         idx_q  <= '0;
         cyc_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         base_q <= base_i;
         len_q  <= len_i;
         adj_q  <= adj_i;
         stb_q  <= stb_i;
         idx_q  <= '0;
         cyc_q  <= '0;
      end else if (busy_q) begin
         if (cap_en_o) begin
            cyc_q <= '0;
            idx_q <= idx_q + 1'b1;
            if (fin_o) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
      end
   end

   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !busy_q) |=> (busy_q && !done_q)); // R3
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !req_i) |=> done_q); // R7
   AST_BUSY_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !done_q); // R7
   AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && req_i) |=> ($stable(base_q) && $stable(len_q) && $stable(adj_q))); // R10
   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= len_q)); // R5
   AST_CAPTURE_AFTER_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en_o |-> !adj_phase_o); // R4
endmodule

// File: rtl/fuse_data_bank.sv
module fuse_data_bank #(
   parameter int unsigned WORDS = 8,
   parameter int unsigned LEN_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic [LEN_W-1:0]   cap_idx,
   input  logic [7:0]         cap_byte,
   output logic [WORDS*32-1:0] words_o
);
   localparam int unsigned NB = WORDS * 4;

   logic [NB-1:0] we;
   logic [7:0]    lane_q [NB];

   for (genvar k = 0; k < NB; k++) begin : g_lane
      assign we[k] = cap_en && (cap_idx == LEN_W'(k));
      assign words_o[8*k +: 8] = lane_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NB; k++) lane_q[k] <= '0;
      end else begin
         for (int k = 0; k < NB; k++) if (we[k]) lane_q[k] <= cap_byte;
      end
   end

   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we)); // R5
endmodule

// File: rtl/fuse_read_ctl.sv
module fuse_read_ctl
   import fuse_rd_pkg::*;
#(
   parameter int unsigned ARRAY_BYTES = 1024,
   parameter int unsigned DATA_WORDS  = 8,
   parameter int unsigned BUS_AW      = 6,
   parameter bit          IRQ_PRESENT = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [BUS_AW-1:0]              bus_addr,
   input  logic                           bus_wr,
   input  logic                           bus_rd,
   input  logic [31:0]                    bus_wdata,
   output logic [31:0]                    bus_rdata,
   output logic                           irq,
   input  logic                           ld_en,
   input  logic [$clog2(ARRAY_BYTES)-1:0] ld_addr,
   input  logic [7:0]                     ld_data
);
   localparam int unsigned FAW   = $clog2(ARRAY_BYTES);
   localparam int unsigned LEN_W = $clog2(DATA_WORDS * 4);

   if (FAW > 10) begin : g_bad_faw
      $error("array too large for the 10-bit address field");
   end
   if (LEN_W > 5 || DATA_WORDS * 4 != (1 << LEN_W)) begin : g_bad_len
      $error("data bank must hold a power-of-two byte count up to 32");
   end
   if (BUS_AW < 6) begin : g_bad_aw
      $error("bus address too narrow for the register map");
   end

   word_t ctrl_q, cfg_q, rd_val;
   logic  busy, done, cap_en, fin, adj_phase;
   logic  wr_ctrl, wr_cfg, req;
   logic [LEN_W-1:0]      cap_idx;
   logic [FAW-1:0]        fuse_addr;
   logic [7:0]            fuse_byte;
   logic [DATA_WORDS*32-1:0] words;
   int unsigned           reg_i;
   logic [1:0]            unused_lsb;
   logic                  unused_phase;

   assign unused_lsb   = bus_addr[1:0];
   assign unused_phase = adj_phase;
   assign reg_i   = 32'(bus_addr[BUS_AW-1:2]);
   assign wr_ctrl = bus_wr && (reg_i == IDX_CTRL);
   assign wr_cfg  = bus_wr && (reg_i == IDX_CFG);
   assign req     = wr_ctrl && bus_wdata[CTRL_RUN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (wr_ctrl && !busy)  ctrl_q <= bus_wdata & CTRL_KEEP;
         else if (fin)          ctrl_q[CTRL_RUN_BIT] <= 1'b0;
         if (wr_cfg)            cfg_q <= bus_wdata & CFG_KEEP;
      end
   end

   fuse_rd_seq #(.FAW(FAW), .LEN_W(LEN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .base_i     (bus_wdata[CTRL_ADDR_LSB +: FAW]),
      .len_i      (bus_wdata[CTRL_LEN_LSB +: LEN_W]),
      .adj_i      (cfg_q[CFG_RADJ_LSB +: 4]),
      .stb_i      (cfg_q[CFG_RSTB_LSB +: 4]),
      .busy_o     (busy),
      .done_o     (done),
      .cap_en_o   (cap_en),
      .fin_o      (fin),
      .adj_phase_o(adj_phase),
      .cap_idx_o  (cap_idx),
      .fuse_addr_o(fuse_addr)
   );

   fuse_byte_array #(.BYTES(ARRAY_BYTES), .AW(FAW)) u_array (
      .clk    (clk),
      .ld_en  (ld_en),
      .ld_addr(ld_addr),
      .ld_data(ld_data),
      .rd_addr(fuse_addr),
      .rd_data(fuse_byte)
   );

   fuse_data_bank #(.WORDS(DATA_WORDS), .LEN_W(LEN_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .cap_idx (cap_idx),
      .cap_byte(fuse_byte),
      .words_o (words)
   );

   always_comb begin
      rd_val = '0;
      if (reg_i == IDX_CTRL) rd_val = ctrl_q;
      if (reg_i == IDX_CFG)  rd_val = cfg_q;
      if (reg_i == IDX_STAT) rd_val = {30'd0, 1'b0, done};
      for (int w = 0; w < DATA_WORDS; w++) begin
         if (reg_i == IDX_DATA + w) rd_val = words[32*w +: 32];
      end
   end

   assign bus_rdata = bus_rd ? rd_val : '0;

   if (IRQ_PRESENT) begin : g_irq
      assign irq = cfg_q[CFG_IE_BIT] & done;
   end else begin : g_no_irq
      assign irq = 1'b0;
   end

   AST_RUN_BIT_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ctrl_q[CTRL_RUN_BIT]); // R3
   AST_FIN_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (!ctrl_q[CTRL_RUN_BIT] && done)); // R7
endmodule

// File: tb/sim_fuse_read_ctl.sv
module sim_fuse_read_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        ld_en = 1'b0;
   logic [9:0]  ld_addr = '0;
   logic [7:0]  ld_data = '0;

   int n_cmp = 0, n_bad = 0, tick = 0;
   bit ended = 0;
   logic [7:0]  rom_img [1024];
   logic [31:0] model_w [8];
   logic [31:0] exp_q [$];

   fuse_read_ctl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
   );

   always #5 clk = ~clk;
   always @(posedge clk) tick <= tick + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int idx, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(idx * 4); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int idx, output logic [31:0] d);
      bus_addr = 6'(idx * 4); bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   // monitor: pops the expected duration and words, compares with the design
   task automatic monitor_burst(input string req, input int elapsed);
      logic [31:0] d;
      chk({req, " R4 duration"}, 32'(elapsed), exp_q.pop_front());
      for (int w = 0; w < 8; w++) begin
         bus_read(3 + w, d);
         chk({req, " R5 data word"}, d, exp_q.pop_front());
      end
   endtask

   // driver: predicts results, pushes them, runs the burst
   task automatic run_burst(input string req, input int base, input int len,
                            input int adj, input int stb, input bit ie, input bit poke);
      logic [31:0] d, ctrl;
      int t0, elapsed;
      int per = adj + 5 + stb;
      bus_write(1, {ie, 7'd0, 4'(adj), 4'(stb), 16'd0});
      for (int k = 0; k <= len; k++)
         model_w[k / 4][8 * (k % 4) +: 8] = rom_img[(base + k) % 1024];
      exp_q.push_back(32'(per * (len + 1)));
      for (int w = 0; w < 8; w++) exp_q.push_back(model_w[w]);
      ctrl = {1'b0, 10'(base), 5'(len), 16'h0001};
      bus_write(0, ctrl);
      t0 = tick;
      bus_read(2, d); chk({req, " R3 done cleared"}, d, 32'h0);
      bus_read(0, d); chk({req, " R3 run bit set"}, d, ctrl);
      if (ie) chk({req, " R8 irq low while busy"}, {31'd0, irq}, 32'h0);
      if (poke) begin
         repeat (5) @(posedge clk);
         bus_write(0, 32'h000F_0001);
         bus_write(1, {ie, 7'd0, 4'd9, 4'd9, 16'd0});
         bus_read(0, d); chk({req, " R10 control write ignored"}, d, ctrl);
      end
      forever begin
         bus_read(2, d);
         if (d[0]) break;
         @(posedge clk); #1;
      end
      elapsed = tick - t0;
      monitor_burst(req, elapsed);
      bus_read(0, d); chk({req, " R7 run bit cleared"}, d, ctrl & 32'hFFFF_FFFE);
      chk({req, " R8 irq"}, {31'd0, irq}, {31'd0, ie});
   endtask

   initial begin
      #1_500_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!ended) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int a = 0; a < 1024; a++) rom_img[a] = 8'((a * 37 + 11) ^ (a >> 2));
      for (int w = 0; w < 8; w++) model_w[w] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      for (int r = 0; r < 11; r++) begin
         bus_read(r, d); chk("R1 reset register", d, 32'h0);
      end
      chk("R1 reset irq", {31'd0, irq}, 32'h0);

      for (int a = 0; a < 1024; a++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = 10'(a); ld_data = rom_img[a];
      end
      @(negedge clk) ld_en = 1'b0;

      run_burst("R5 full aligned", 0, 31, 0, 0, 1'b0, 1'b0);
      run_burst("R4 slow timing", 64, 31, 3, 2, 1'b0, 1'b0);
      run_burst("R5 short unaligned", 100, 3, 1, 0, 1'b0, 1'b0);
      run_burst("R6 wrap", 1016, 15, 0, 1, 1'b0, 1'b0);
      run_burst("R10 R11 busy writes", 128, 31, 1, 1, 1'b0, 1'b1);
      run_burst("R4 max timing", 7, 0, 15, 15, 1'b1, 1'b0);

      // R7 done sticky
      repeat (20) @(posedge clk);
      bus_read(2, d); chk("R7 done sticky", d, 32'h1);

      // R8 irq follows enable
      bus_write(1, 32'h0);
      chk("R8 irq off with enable low", {31'd0, irq}, 32'h0);
      bus_write(1, 32'h8000_0000);
      chk("R8 irq on with enable high", {31'd0, irq}, 32'h1);

      // R2 field masks
      bus_write(1, 32'hFFFF_FFFF);
      bus_read(1, d); chk("R2 config mask", d, 32'h80FF_FFFF);
      bus_write(0, 32'hFFFF_FFFE);
      bus_read(0, d); chk("R2 control mask", d, 32'h7FFF_8002);

      // R9 write/program requests do nothing
      bus_write(0, 32'h0000_8002);
      bus_read(0, d); chk("R9 request bits stored", d, 32'h0000_8002);
      repeat (60) @(posedge clk);
      #1;
      bus_read(2, d); chk("R9 status unchanged, write-done 0", d, 32'h1);
      for (int w = 0; w < 8; w++) begin
         bus_read(3 + w, d); chk("R9 data unchanged", d, model_w[w]);
      end

      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule